// File: doc/BRIEF.md
# Prescaled Match/Capture Timer

The block is a 32-bit timer peripheral on a simple register bus with single-cycle writes and combinational reads. A prescale counter divides the clock: it runs from zero up to a programmed limit, then wraps and emits a tick. Each tick advances the main counter by one. Software can load either counter through the bus.

Four compare registers are checked against the value the main counter takes on each tick. Two external capture lines pass through a synchroniser, and each rising edge copies the main counter into a capture register. Match and capture events set flags in a status register. Writing ones to that register clears flags, and a single interrupt line is high whenever any flag is set.

Counting is governed by a control register. Its two bits encode four named control states: HALT (00), COUNT (01), CLEAR_HALT (10) and CLEAR_COUNT (11). Any control write can move the block from any state to any other. In both CLEAR states both counters are forced to zero, whatever the enable bit says.

Top module: `ptimer_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register map, as byte offsets: status flags 0x00, control 0x04, main counter 0x08, prescale limit 0x0C, prescale counter 0x10, compare 0 to 3 at 0x18/0x1C/0x20/0x24, capture 0 and 1 at 0x28/0x2C. Unmapped offsets read zero.
- R3: Control bit 0 is the enable bit. While the control value is 00 (HALT), both counters hold their values.
- R4: While control bit 1 is set, both counters become zero on the next clock edge and stay zero.
- R5: In COUNT, with prescale limit P, the prescale counter runs 0..P. The main counter increments each time the prescale counter wraps. After N counting edges from zero, the main counter reads N/(P+1) and the prescale counter reads N mod (P+1).
- R6: The main counter wraps from 0xFFFFFFFF to 0. The wrap alone sets no flag.
- R7: Status bit i (i=0..3) is set on the edge where the main counter advances to the value of compare i. With compare 0 set to zero, the wrap sets bit 0.
- R8: Status bit 4+j is set when capture line j rises (after two synchronising flops). On that edge, capture register j takes the main counter value. A high level held steady, or a falling edge, captures nothing.
- R9: Writing status flags clears each bit written as one and leaves bits written as zero unchanged. When a hardware set and a clear hit the same bit in one cycle, the bit stays set.
- R10: `irq` is high exactly when any of the six status bits is set.
- R11: Reserved bits read zero, and writes to them have no effect. Control bits 31:2 and status bits 31:6 are reserved.
- R12: A bus write to a counter takes priority over counting in that cycle. Control bit 1 takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_in | input | 2 | Asynchronous capture lines |
| irq | output | 1 | OR of all status flags |

## Verification
The counting function is driven by random prescale limits and random run lengths. Each run is stopped by a control write, so the counter pair can be compared with the quotient and remainder of the edge count. This separates a wrong prescale period from an off-by-one at the enable boundary.

A random compare value, placed either inside or just past the range the counter swept, shows whether a flag fires for a value that was reached and stays quiet for one that was not. Directed runs cover the following cases:
- a wrap, checked once with no matching compare and once with compare zero;
- a capture pulse, a capture line held high, and a falling edge;
- a clear that lands in the same cycle as a match set;
- writes to reserved bits.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    localparam int N_MATCH = 4;
    localparam int N_CAP   = 2;
    localparam int N_FLAG  = N_MATCH + N_CAP;

    localparam logic [7:0] OFS_FLAGS  = 8'h00;
    localparam logic [7:0] OFS_CTRL   = 8'h04;
    localparam logic [7:0] OFS_TC     = 8'h08;
    localparam logic [7:0] OFS_PLIM   = 8'h0C;
    localparam logic [7:0] OFS_PCNT   = 8'h10;
    localparam logic [7:0] OFS_MATCH0 = 8'h18;
    localparam logic [7:0] OFS_CAP0   = 8'h28;

    typedef enum logic [1:0] {
        ST_HALT        = 2'b00,
        ST_COUNT       = 2'b01,
        ST_CLEAR_HALT  = 2'b10,
        ST_CLEAR_COUNT = 2'b11
    } tmr_state_e;

endpackage

// File: rtl/ptimer_ctrl.sv
module ptimer_ctrl
    import ptimer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_wdata,
    output logic [1:0] ctrl_bits,
    output logic       cnt_en,
    output logic       cnt_clr
);

    tmr_state_e state_q;

    // State register: a control write moves directly to the encoded state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else if (ctrl_wr) begin
            state_q <= tmr_state_e'(ctrl_wdata);
        end
    end

    // Output decode for each state.
    always_comb begin
        cnt_en  = 1'b0;
        cnt_clr = 1'b0;
        unique case (state_q)
            ST_HALT:        begin cnt_en = 1'b0; cnt_clr = 1'b0; end
            ST_COUNT:       begin cnt_en = 1'b1; cnt_clr = 1'b0; end
            ST_CLEAR_HALT:  begin cnt_en = 1'b0; cnt_clr = 1'b1; end
            ST_CLEAR_COUNT: begin cnt_en = 1'b0; cnt_clr = 1'b1; end
            default:        begin cnt_en = 1'b0; cnt_clr = 1'b0; end
        endcase
    end

    assign ctrl_bits = state_q;

endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             cnt_clr,
    input  logic [CNT_W-1:0] plim,
    input  logic             wr_tc,
    input  logic             wr_pc,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] tc_q,
    output logic [CNT_W-1:0] pc_q,
    output logic [CNT_W-1:0] tc_inc,
    output logic             tick
);

    logic pc_wrap;

    assign pc_wrap = cnt_en && (pc_q == plim);
    assign tc_inc  = tc_q + {{(CNT_W-1){1'b0}}, 1'b1};
    assign tick    = pc_wrap && !wr_tc && !cnt_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (cnt_clr) begin
            pc_q <= '0;
        end else if (wr_pc) begin
            pc_q <= wdata;
        end else if (pc_wrap) begin
            pc_q <= '0;
        end else if (cnt_en) begin
            pc_q <= pc_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q <= '0;
        end else if (cnt_clr) begin
            tc_q <= '0;
        end else if (wr_tc) begin
            tc_q <= wdata;
        end else if (tick) begin
            tc_q <= tc_inc;
        end
    end

endmodule

// File: rtl/ptimer_capture.sv
module ptimer_capture #(
    parameter int CNT_W = 32,
    parameter int N_CH  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH-1:0]        cap_in,
    input  logic [CNT_W-1:0]       tc_q,
    output logic [N_CH-1:0]        cap_evt,
    output logic [N_CH*CNT_W-1:0]  cap_vals
);

    for (genvar j = 0; j < N_CH; j++) begin : g_ch
        logic             s1_q, s2_q, prev_q;
        logic [CNT_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= cap_in[j];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end

        assign cap_evt[j] = s2_q && !prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (cap_evt[j]) begin
                val_q <= tc_q;
            end
        end

        assign cap_vals[j*CNT_W +: CNT_W] = val_q;
    end

endmodule

// File: rtl/ptimer_flags.sv
module ptimer_flags #(
    parameter int N_FLAG = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] set_vec,
    input  logic              clr_wr,
    input  logic [N_FLAG-1:0] clr_mask,
    output logic [N_FLAG-1:0] flags_q,
    output logic              irq
);

    logic [N_FLAG-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;

    // Hardware sets are ORed in after the clear, so a set wins a collision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_eff) | set_vec;
        end
    end

    assign irq = |flags_q;

endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
    import ptimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [N_CAP-1:0]  cap_in,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(OFS_FLAGS);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_TC    = ADDR_W'(OFS_TC);
    localparam logic [ADDR_W-1:0] A_PLIM  = ADDR_W'(OFS_PLIM);
    localparam logic [ADDR_W-1:0] A_PCNT  = ADDR_W'(OFS_PCNT);
    localparam logic [ADDR_W-1:0] A_M0    = ADDR_W'(OFS_MATCH0);
    localparam logic [ADDR_W-1:0] A_C0    = ADDR_W'(OFS_CAP0);

    logic [1:0]             ctrl_bits;
    logic                   cnt_en, cnt_clr;
    logic [CNT_W-1:0]       tc_val, pc_val, plim_q, tc_inc;
    logic                   tick;
    logic [N_FLAG-1:0]      flags, set_vec;
    logic [N_CAP-1:0]       cap_evt;
    logic [N_CAP*CNT_W-1:0] cap_vals;
    logic [N_MATCH*CNT_W-1:0] match_flat;
    logic [N_MATCH-1:0]     match_hit;

    ptimer_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (bus_wr && bus_addr == A_CTRL),
        .ctrl_wdata (bus_wdata[1:0]),
        .ctrl_bits  (ctrl_bits),
        .cnt_en     (cnt_en),
        .cnt_clr    (cnt_clr)
    );

    ptimer_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .cnt_clr (cnt_clr),
        .plim    (plim_q),
        .wr_tc   (bus_wr && bus_addr == A_TC),
        .wr_pc   (bus_wr && bus_addr == A_PCNT),
        .wdata   (bus_wdata),
        .tc_q    (tc_val),
        .pc_q    (pc_val),
        .tc_inc  (tc_inc),
        .tick    (tick)
    );

    ptimer_capture #(.CNT_W(CNT_W), .N_CH(N_CAP)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_in   (cap_in),
        .tc_q     (tc_val),
        .cap_evt  (cap_evt),
        .cap_vals (cap_vals)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plim_q <= '0;
        end else if (bus_wr && bus_addr == A_PLIM) begin
            plim_q <= bus_wdata;
        end
    end

    for (genvar i = 0; i < N_MATCH; i++) begin : g_match
        logic [CNT_W-1:0] m_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_q <= '0;
            end else if (bus_wr && bus_addr == A_M0 + ADDR_W'(4*i)) begin
                m_q <= bus_wdata;
            end
        end
        assign match_flat[i*CNT_W +: CNT_W] = m_q;
        assign match_hit[i] = tick && (tc_inc == m_q);
    end

    assign set_vec = {cap_evt, match_hit};

    ptimer_flags #(.N_FLAG(N_FLAG)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (bus_wr && bus_addr == A_FLAGS),
        .clr_mask (bus_wdata[N_FLAG-1:0]),
        .flags_q  (flags),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_FLAGS) bus_rdata = CNT_W'(flags);
        if (bus_addr == A_CTRL)  bus_rdata = CNT_W'(ctrl_bits);
        if (bus_addr == A_TC)    bus_rdata = tc_val;
        if (bus_addr == A_PLIM)  bus_rdata = plim_q;
        if (bus_addr == A_PCNT)  bus_rdata = pc_val;
        for (int i = 0; i < N_MATCH; i++) begin
            if (bus_addr == A_M0 + ADDR_W'(4*i)) bus_rdata = match_flat[i*CNT_W +: CNT_W];
        end
        for (int j = 0; j < N_CAP; j++) begin
            if (bus_addr == A_C0 + ADDR_W'(4*j)) bus_rdata = cap_vals[j*CNT_W +: CNT_W];
        end
    end

endmodule

// File: rtl/ptimer_chk.sv
module ptimer_chk #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [1:0]        ctrl_bits,
    input logic [CNT_W-1:0]  tc_val,
    input logic [CNT_W-1:0]  pc_val,
    input logic [5:0]        flags,
    input logic [CNT_W-1:0]  cap0
);

    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(8'h08) || bus_addr == ADDR_W'(8'h10));

    assert_clear_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_bits[1] |=> (tc_val == '0 && pc_val == '0));

    assert_halt_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits == 2'b00 && !cnt_wr) |=> ($stable(tc_val) && $stable(pc_val)));

    assert_match_on_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> ((tc_val - $past(tc_val)) == CNT_W'(1)));

    assert_capture_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[4]) |-> (cap0 == $past(tc_val)));

    for (genvar i = 0; i < 6; i++) begin : g_w1c
        assert_clear_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(bus_wr && bus_addr == ADDR_W'(8'h00) && bus_wdata[i]));
    end

endmodule

bind ptimer_top ptimer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_bits (ctrl_bits),
    .tc_val    (tc_val),
    .pc_val    (pc_val),
    .flags     (flags),
    .cap0      (cap_vals[CNT_W-1:0])
);

// File: tb/ptimer_top_tb.sv
module ptimer_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  cap_in = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptimer_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq)
    );

    localparam logic [7:0] A_FL = 8'h00, A_CT = 8'h04, A_TC = 8'h08, A_PL = 8'h0C,
                           A_PC = 8'h10, A_M0 = 8'h18, A_M1 = 8'h1C, A_M2 = 8'h20,
                           A_M3 = 8'h24, A_C0 = 8'h28;

    function automatic logic [31:0] exp_tc(input int n, input int p);
        return 32'(n / (p + 1));
    endfunction

    function automatic logic [31:0] exp_pc(input int n, input int p);
        return 32'(n % (p + 1));
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int seed;
        seed = 32'h1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 12; a++) rdchk("R1 reset read", 8'(4*a), 32'h0);
        chk("R1 irq low", {31'b0, irq}, 32'h0);

        // R11 reserved bits, R2 unmapped offset
        wr(A_CT, 32'hFFFF_FFFC);
        rdchk("R11 ctrl reserved", A_CT, 32'h0);
        wr(8'h14, 32'hDEAD_BEEF);
        rdchk("R2 unmapped 0x14", 8'h14, 32'h0);
        wr(A_M2, 32'h0000_A5A5);
        rdchk("R2 compare2 offset", A_M2, 32'h0000_A5A5);

        // R5 and R7 random runs
        for (int it = 0; it < 24; it++) begin
            int p, n, m;
            logic [31:0] et;
            p = int'($urandom_range(0, 6));
            n = int'($urandom_range(1, 60));
            et = exp_tc(n, p);
            m = int'($urandom_range(1, int'(et) + 2));
            wr(A_PL, 32'(p));
            wr(A_M0, 32'(m));
            wr(A_M1, 32'hFFFF_0000); wr(A_M2, 32'hFFFF_0000); wr(A_M3, 32'hFFFF_0000);
            wr(A_CT, 32'h2);
            wr(A_FL, 32'h3F);
            wr(A_CT, 32'h1);
            repeat (n - 1) @(posedge clk);
            wr(A_CT, 32'h0);
            rdchk("R5 main count", A_TC, et);
            rdchk("R5 prescale count", A_PC, exp_pc(n, p));
            rdchk("R7 compare0 flag", A_FL, (32'(m) <= et) ? 32'h1 : 32'h0);
            chk("R10 irq follows flags", {31'b0, irq}, (32'(m) <= et) ? 32'h1 : 32'h0);
        end

        // R3 halt holds
        rd(A_TC, d);
        repeat (10) @(posedge clk);
        rdchk("R3 halt holds count", A_TC, d);

        // R4 clear bit with enable held
        wr(A_CT, 32'h3);
        repeat (5) @(posedge clk);
        rdchk("R4 count zero", A_TC, 32'h0);
        rdchk("R4 prescale zero", A_PC, 32'h0);
        wr(A_TC, 32'h55);
        rdchk("R12 clear beats write", A_TC, 32'h0);
        wr(A_CT, 32'h0);

        // R6 wrap without flag, then R7 wrap via compare 0
        wr(A_PL, 32'h0);
        wr(A_M0, 32'h12345);
        wr(A_FL, 32'h3F);
        wr(A_TC, 32'hFFFF_FFFE);
        wr(A_CT, 32'h1);
        @(posedge clk);
        wr(A_CT, 32'h0);
        rdchk("R6 wrapped count", A_TC, 32'h0);
        rdchk("R6 no flag on wrap", A_FL, 32'h0);
        wr(A_M0, 32'h0);
        wr(A_TC, 32'hFFFF_FFFE);
        wr(A_CT, 32'h1);
        @(posedge clk);
        wr(A_CT, 32'h0);
        rdchk("R7 wrap via compare0", A_FL, 32'h1);

        // R8 capture while halted
        wr(A_TC, 32'h0000_0777);
        @(negedge clk); cap_in[0] = 1'b1;
        repeat (6) @(posedge clk);
        rdchk("R8 capture value", A_C0, 32'h0000_0777);
        rdchk("R8 capture flag", A_FL, 32'h11);
        wr(A_TC, 32'h0000_0999);
        repeat (6) @(posedge clk);
        rdchk("R8 steady high no capture", A_C0, 32'h0000_0777);
        @(negedge clk); cap_in[0] = 1'b0;
        repeat (6) @(posedge clk);
        rdchk("R8 falling no capture", A_C0, 32'h0000_0777);

        // R9 write-one-clear
        wr(A_FL, 32'h10);
        rdchk("R9 clear bit4 only", A_FL, 32'h1);
        wr(A_FL, 32'h0);
        rdchk("R9 zero write no effect", A_FL, 32'h1);
        wr(A_FL, 32'hFFFF_FFFF);
        rdchk("R11 status clear all", A_FL, 32'h0);
        chk("R10 irq low", {31'b0, irq}, 32'h0);

        // R9 set wins over simultaneous clear
        wr(A_M0, 32'hFFFF_0000);
        wr(A_M1, 32'h5);
        wr(A_TC, 32'h4);
        wr(A_CT, 32'h1);
        wr(A_FL, 32'h2);
        wr(A_CT, 32'h0);
        rdchk("R9 set wins", A_FL, 32'h2);
        rdchk("R5 count after collide", A_TC, 32'h6);

        // R12 write beats counting
        wr(A_PL, 32'h0);
        wr(A_CT, 32'h1);
        wr(A_TC, 32'h100);
        wr(A_CT, 32'h0);
        rdchk("R12 write then one step", A_TC, 32'h101);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule